// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns segment-relative references into flat 20-bit physical byte addresses. It keeps four 16-bit segment base registers and a 16-bit instruction pointer. Each base names the lowest byte of a 64 KB window. A physical address is formed by moving the base up by four bit positions and adding a 16-bit offset, which reaches a 1 MB space.

Two addresses are produced all the time. The data address combines the segment that a select input picks with an offset supplied by the caller. The fetch address always combines the code segment with the instruction pointer.

A single write port updates one segment base at a time. The instruction pointer can be loaded directly for jumps, or advanced by one or two bytes per fetch. Both addresses are combinational views of the current register contents, so the fetch address in a given cycle is the one that belongs to the pointer before that cycle's update.

Top module: `segaddr_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, all four segment bases and the instruction pointer become 0. Afterwards `fetch_paddr` is 0, and `data_paddr` equals the offset for any select.
- R2: `data_paddr` equals the selected base times 16 plus `data_offset`. For example, base 1005h with offset 5555h gives 155A5h.
- R3: Any carry out of bit 19 is dropped, so addresses wrap modulo 2^20. For example, base FFFFh with offset FFFFh gives 0FFEFh, and base FFFFh with offset 0010h gives 00000h.
- R4: The segment select encoding, used for both `seg_wr_sel` and `data_seg_sel`, is 0 = code, 1 = stack, 2 = extra, 3 = data.
- R5: With `seg_wr_en` high, the base chosen by `seg_wr_sel` takes `seg_wr_data` at the next rising edge and not before. The other bases are unchanged. With `seg_wr_en` low, no base changes.
- R6: `fetch_paddr` equals the code base times 16 plus the instruction pointer, modulo 2^20, whatever `data_seg_sel` and `data_offset` are.
- R7: With `ip_adv` high and `ip_load` low, the pointer grows at the next edge by 2 if `ip_two` is high and by 1 otherwise, wrapping modulo 2^16. With both low, it holds.
- R8: With `ip_load` high, the pointer takes `ip_load_val` at the next edge, whatever `ip_adv` is.
- R9: Both address outputs follow the current register values combinationally. In the cycle where a pointer update is requested, `fetch_paddr` still shows the pre-update pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| seg_wr_en | input | 1 | Segment base write enable |
| seg_wr_sel | input | 2 | Segment to write (0 code, 1 stack, 2 extra, 3 data) |
| seg_wr_data | input | 16 | New segment base value |
| data_seg_sel | input | 2 | Segment used for the data address |
| data_offset | input | 16 | Offset for the data address |
| ip_load | input | 1 | Load the instruction pointer |
| ip_load_val | input | 16 | Value to load into the pointer |
| ip_adv | input | 1 | Advance the pointer |
| ip_two | input | 1 | Advance by 2 instead of 1 |
| data_paddr | output | 20 | Physical data address |
| fetch_paddr | output | 20 | Physical code fetch address |

## Verification
The properties assume that every control input is driven to a known 0 or 1 in every cycle after reset. They also assume that reset is held through the first clock edge, so that each past-value reference starts from a defined state.

The stimulus meets both conditions. It holds reset from time zero across several edges. It then changes inputs only shortly after a rising edge, and returns every enable to zero at the end of each scenario. That gives the write, load and advance checks a known starting point.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;
  localparam int SEG_W_DEF  = 16;
  localparam int OFF_W_DEF  = 16;
  localparam int SHIFT_DEF  = 4;
  localparam int N_SEGS_DEF = 4;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_STACK = 2'd1,
    SEG_EXTRA = 2'd2,
    SEG_DATA  = 2'd3
  } seg_id_e;
endpackage

// File: rtl/segaddr_segfile.sv
module segaddr_segfile #(
  parameter int N_SEGS   = segaddr_pkg::N_SEGS_DEF,
  parameter int SEG_W    = segaddr_pkg::SEG_W_DEF,
  parameter int CODE_IDX = int'(segaddr_pkg::SEG_CODE),
  localparam int SEL_W   = $clog2(N_SEGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [SEG_W-1:0] rd_data,
  output logic [SEG_W-1:0] code_data
);
  logic [SEG_W-1:0]  base_q [N_SEGS];
  logic [N_SEGS-1:0] wr_hit;

  // one-hot write decode
  for (genvar gi = 0; gi < N_SEGS; gi++) begin : g_dec
    assign wr_hit[gi] = wr_en && (wr_sel == SEL_W'(gi));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_SEGS; i++) base_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_SEGS; i++) begin
        if (wr_hit[i]) base_q[i] <= wr_data;
      end
    end
  end

  assign rd_data   = base_q[rd_sel];
  assign code_data = base_q[CODE_IDX];
endmodule

// File: rtl/segaddr_ip.sv
module segaddr_ip #(
  parameter int W = segaddr_pkg::OFF_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         adv,
  input  logic         two,
  output logic [W-1:0] ip_o
);
  logic [W-1:0] ip_q;
  logic [W-1:0] step;

  assign step = two ? W'(2) : W'(1);

  always_ff @(posedge clk) begin
    if (rst)       ip_q <= '0;
    else if (load) ip_q <= load_val;
    else if (adv)  ip_q <= ip_q + step;
  end

  assign ip_o = ip_q;
endmodule

// File: rtl/segaddr_compose.sv
module segaddr_compose #(
  parameter int SEG_W = segaddr_pkg::SEG_W_DEF,
  parameter int OFF_W = segaddr_pkg::OFF_W_DEF,
  parameter int SHIFT = segaddr_pkg::SHIFT_DEF,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0] base_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PA_W-1:0]  paddr_o
);
  logic [PA_W-1:0] base_ext;
  logic [PA_W-1:0] off_ext;

  assign base_ext = {base_i, {SHIFT{1'b0}}};
  assign off_ext  = {{(PA_W-OFF_W){1'b0}}, off_i};
  // sum is truncated to PA_W: carry beyond the top bit is dropped
  assign paddr_o  = base_ext + off_ext;
endmodule

// File: rtl/segaddr_unit.sv
module segaddr_unit #(
  parameter int SEG_W  = segaddr_pkg::SEG_W_DEF,
  parameter int OFF_W  = segaddr_pkg::OFF_W_DEF,
  parameter int SHIFT  = segaddr_pkg::SHIFT_DEF,
  parameter int N_SEGS = segaddr_pkg::N_SEGS_DEF,
  localparam int SEL_W = $clog2(N_SEGS),
  localparam int PA_W  = SEG_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seg_wr_en,
  input  logic [SEL_W-1:0] seg_wr_sel,
  input  logic [SEG_W-1:0] seg_wr_data,
  input  logic [SEL_W-1:0] data_seg_sel,
  input  logic [OFF_W-1:0] data_offset,
  input  logic             ip_load,
  input  logic [OFF_W-1:0] ip_load_val,
  input  logic             ip_adv,
  input  logic             ip_two,
  output logic [PA_W-1:0]  data_paddr,
  output logic [PA_W-1:0]  fetch_paddr
);
  logic [SEG_W-1:0] data_base;
  logic [SEG_W-1:0] code_base;
  logic [OFF_W-1:0] ip_q;

  segaddr_segfile #(
    .N_SEGS   (N_SEGS),
    .SEG_W    (SEG_W),
    .CODE_IDX (int'(segaddr_pkg::SEG_CODE))
  ) u_segfile (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (seg_wr_en),
    .wr_sel    (seg_wr_sel),
    .wr_data   (seg_wr_data),
    .rd_sel    (data_seg_sel),
    .rd_data   (data_base),
    .code_data (code_base)
  );

  segaddr_ip #(.W(OFF_W)) u_ip (
    .clk      (clk),
    .rst      (rst),
    .load     (ip_load),
    .load_val (ip_load_val),
    .adv      (ip_adv),
    .two      (ip_two),
    .ip_o     (ip_q)
  );

  segaddr_compose #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_data_pa (
    .base_i  (data_base),
    .off_i   (data_offset),
    .paddr_o (data_paddr)
  );

  segaddr_compose #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_fetch_pa (
    .base_i  (code_base),
    .off_i   (ip_q),
    .paddr_o (fetch_paddr)
  );
endmodule

// File: rtl/segaddr_checker.sv
module segaddr_checker #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int SEL_W = 2,
  localparam int PA_W = SEG_W + SHIFT
) (
  input logic             clk,
  input logic             rst,
  input logic             seg_wr_en,
  input logic [SEL_W-1:0] seg_wr_sel,
  input logic [SEG_W-1:0] seg_wr_data,
  input logic [SEL_W-1:0] data_seg_sel,
  input logic [OFF_W-1:0] data_offset,
  input logic             ip_load,
  input logic [OFF_W-1:0] ip_load_val,
  input logic             ip_adv,
  input logic             ip_two,
  input logic [PA_W-1:0]  data_paddr,
  input logic [PA_W-1:0]  fetch_paddr,
  input logic [OFF_W-1:0] ip_q
);
  function automatic logic [PA_W-1:0] expect_pa(input logic [SEG_W-1:0] b,
                                                 input logic [OFF_W-1:0] o);
    return PA_W'({b, {SHIFT{1'b0}}}) + PA_W'(o);
  endfunction

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ip_q == '0) && (fetch_paddr == '0)); // R1

  AST_SEG_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(seg_wr_en) && (data_seg_sel == $past(seg_wr_sel)))
      |-> data_paddr == expect_pa($past(seg_wr_data), data_offset)); // R5

  AST_IP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (ip_adv && !ip_load) |=> ip_q == $past(ip_q) + ($past(ip_two) ? OFF_W'(2) : OFF_W'(1))); // R7

  AST_IP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ip_adv && !ip_load) |=> $stable(ip_q)); // R7

  AST_IP_LOAD: assert property (@(posedge clk) disable iff (rst)
    ip_load |=> ip_q == $past(ip_load_val)); // R8
endmodule

bind segaddr_unit segaddr_checker #(
  .SEG_W (SEG_W),
  .OFF_W (OFF_W),
  .SHIFT (SHIFT),
  .SEL_W (SEL_W)
) u_chk (.*);

// File: tb/segaddr_unit_bench.sv
module segaddr_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = '0;
  logic [15:0] seg_wr_data = '0;
  logic [1:0]  data_seg_sel = '0;
  logic [15:0] data_offset = '0;
  logic        ip_load = 1'b0;
  logic [15:0] ip_load_val = '0;
  logic        ip_adv = 1'b0;
  logic        ip_two = 1'b0;
  logic [19:0] data_paddr;
  logic [19:0] fetch_paddr;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segaddr_unit u_segaddr_unit (
    .clk, .rst, .seg_wr_en, .seg_wr_sel, .seg_wr_data, .data_seg_sel,
    .data_offset, .ip_load, .ip_load_val, .ip_adv, .ip_two,
    .data_paddr, .fetch_paddr
  );

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_seg(input logic [1:0] sel, input logic [15:0] val);
    seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = val;
    step();
    seg_wr_en = 1'b0;
  endtask

  task automatic load_ip(input logic [15:0] val);
    ip_load = 1'b1; ip_load_val = val;
    step();
    ip_load = 1'b0;
  endtask

  task automatic t_reset();
    data_offset = 16'h0000;
    for (int s = 0; s < 4; s++) begin
      data_seg_sel = 2'(s);
      #1 chk("R1 data after reset", data_paddr, 20'h00000);
    end
    chk("R1 fetch after reset", fetch_paddr, 20'h00000);
    wr_seg(2'd0, 16'h4321);
    load_ip(16'h0042);
    rst = 1'b1; step(); rst = 1'b0;
    data_seg_sel = 2'd0; data_offset = 16'h0007;
    #1 chk("R1 reset clears code base", data_paddr, 20'h00007);
    chk("R1 reset clears ip", fetch_paddr, 20'h00000);
  endtask

  task automatic t_compose();
    wr_seg(2'd3, 16'h1005);
    data_seg_sel = 2'd3; data_offset = 16'h5555;
    #1 chk("R2 1005:5555", data_paddr, 20'h155A5);
    wr_seg(2'd2, 16'hABCD);
    data_seg_sel = 2'd2; data_offset = 16'h0000;
    #1 chk("R2 ABCD:0000", data_paddr, 20'hABCD0);
    data_offset = 16'h0F0F;
    #1 chk("R2 ABCD:0F0F", data_paddr, 20'hACBDF);
  endtask

  task automatic t_wrap();
    wr_seg(2'd1, 16'hFFFF);
    data_seg_sel = 2'd1; data_offset = 16'hFFFF;
    #1 chk("R3 FFFF:FFFF wraps", data_paddr, 20'h0FFEF);
    data_offset = 16'h0010;
    #1 chk("R3 FFFF:0010 wraps", data_paddr, 20'h00000);
  endtask

  task automatic t_select();
    wr_seg(2'd0, 16'h1111);
    wr_seg(2'd1, 16'h2222);
    wr_seg(2'd2, 16'h3333);
    wr_seg(2'd3, 16'h4444);
    data_offset = 16'h0000;
    data_seg_sel = 2'd0; #1 chk("R4 sel 0 code",  data_paddr, 20'h11110);
    data_seg_sel = 2'd1; #1 chk("R4 sel 1 stack", data_paddr, 20'h22220);
    data_seg_sel = 2'd2; #1 chk("R4 sel 2 extra", data_paddr, 20'h33330);
    data_seg_sel = 2'd3; #1 chk("R4 sel 3 data",  data_paddr, 20'h44440);
  endtask

  task automatic t_write_timing();
    data_seg_sel = 2'd3; data_offset = 16'h0000;
    seg_wr_en = 1'b1; seg_wr_sel = 2'd3; seg_wr_data = 16'h0800;
    #1 chk("R5 old base before edge", data_paddr, 20'h44440);
    step(); seg_wr_en = 1'b0;
    #1 chk("R5 new base after edge", data_paddr, 20'h08000);
    data_seg_sel = 2'd2;
    #1 chk("R5 neighbour untouched", data_paddr, 20'h33330);
    seg_wr_sel = 2'd2; seg_wr_data = 16'hFFFF;
    step();
    #1 chk("R5 no write when disabled", data_paddr, 20'h33330);
  endtask

  task automatic t_fetch();
    wr_seg(2'd0, 16'h2000);
    load_ip(16'h0100);
    data_seg_sel = 2'd1; data_offset = 16'hFFFF;
    #1 chk("R6 fetch CS:IP", fetch_paddr, 20'h20100);
    data_seg_sel = 2'd3; data_offset = 16'h1234;
    #1 chk("R6 fetch ignores data select", fetch_paddr, 20'h20100);
    wr_seg(2'd0, 16'hFFFF);
    load_ip(16'h0020);
    #1 chk("R6 fetch wraps", fetch_paddr, 20'h00010);
  endtask

  task automatic t_ip_step();
    wr_seg(2'd0, 16'h0000);
    load_ip(16'h0010);
    ip_adv = 1'b1; ip_two = 1'b0;
    #1 chk("R9 pre-update ip visible", fetch_paddr, 20'h00010);
    step(); ip_adv = 1'b0;
    #1 chk("R7 advance by 1", fetch_paddr, 20'h00011);
    ip_adv = 1'b1; ip_two = 1'b1;
    step(); ip_adv = 1'b0; ip_two = 1'b0;
    #1 chk("R7 advance by 2", fetch_paddr, 20'h00013);
    step();
    #1 chk("R7 hold when idle", fetch_paddr, 20'h00013);
    load_ip(16'hFFFF);
    ip_adv = 1'b1; ip_two = 1'b1;
    step(); ip_adv = 1'b0; ip_two = 1'b0;
    #1 chk("R7 ip wraps at 16 bits", fetch_paddr, 20'h00001);
  endtask

  task automatic t_ip_prio();
    ip_load = 1'b1; ip_load_val = 16'h1234; ip_adv = 1'b1; ip_two = 1'b1;
    #1 chk("R9 fetch before load edge", fetch_paddr, 20'h00001);
    step();
    ip_load = 1'b0; ip_adv = 1'b0; ip_two = 1'b0;
    #1 chk("R8 load beats advance", fetch_paddr, 20'h01234);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_compose();
    t_wrap();
    t_select();
    t_write_timing();
    t_fetch();
    t_ip_step();
    t_ip_prio();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule